// File: doc/BRIEF.md
# I2C Master Register Buffer Unit

This block is the byte-wide register front end of an I2C master controller. Software reaches it through a plain 8-bit read/write bus with a 5-bit byte offset. Behind that bus it holds a four-byte master data queue, the target address bytes and the control, mode, status and extended-status registers. It also performs the soft reset. A transfer sequencer sits beside it. The sequencer receives the control byte and a one-cycle start pulse, takes outgoing bytes from the head of the queue, appends received bytes to its tail, and reports completion and abort events, which this block turns into status bits and an interrupt line. The bit-level bus timing is not part of this block, and the clock divider byte is only stored.

The data queue is a small state machine with three states: `BUF_EMPTY`, `BUF_PARTIAL` and `BUF_FULL`.
- `PUSH_FIRST` (empty to partial) happens when a byte is appended to an empty queue.
- `PUSH_LAST` (partial to full) happens when the fourth byte is appended.
- `POP_FROM_FULL` (full to partial) and `POP_LAST` (partial to empty) happen when a byte is taken from the head, and the remaining bytes move one place toward the front.
- `FLUSH` (any state to empty) clears every byte.

Reading offset 0 takes the head byte. A read of an empty queue returns 0xFF.

Top module: `i2cm_regfile`

## Requirements
- R1: A write to offset 0, or a `seq_push`, appends a byte at the tail. `buf_has` (status bit 5) rises with the first byte, and `buf_full` (status bit 4) rises with the fourth.
- R2: An append while the queue holds four bytes is ignored: contents and flags stay unchanged.
- R3: A read of offset 0 with an empty queue returns 0xFF and changes nothing.
- R4: A read of offset 0 with data returns the head byte and shifts the remaining bytes forward. The full flag drops when the read is taken from a full queue, and the has-data flag drops when the last byte leaves.
- R5: A write to offset 7 (mode) stores only the bits in mask 0x3D. A 1 in bit 6 of that write flushes the queue: all bytes go to zero and both flags clear.
- R6: `seq_irq` with mode bit 2 set raises status bit 1 and `irq`. A write to offset 8 with bit 1 set clears status bit 1, and it also drops `irq` only while mode bit 2 is set. A 1 in bit 2 of a status write has no effect. The status byte reads as {0,0,has,full,0,error,irq-active,0}.
- R7: Hard reset and soft reset (a write to offset 15 with bit 0 set) clear the queue, control, mode, status, clock divider (offset 11), interrupt mask (offset 12) and transfer count (offset 14). They also set extended status to 0x40 and direct control (offset 16, low 4 bits) to 0xF. A soft reset leaves the address bytes (offsets 4 and 5) unchanged, while a hard reset clears them.
- R8: A read of offset 9 returns the stored extended status with `bus_busy` in bit 4. A write to offset 9 clears the bits in (value & 0x8F). `seq_err` sets extended-status bit 0 and status bit 2.
- R9: Every read strobe returns data with `reg_rvalid` one cycle later. Only a read of offset 0 alters the queue.
- R10: `seq_head` shows the head byte and `seq_pop` removes it. When pops and pushes meet in one cycle the pop is taken and the push is dropped, and a flush overrides both.
- R11: A write to offset 6 stores (value & 0xFE). If bit 0 is set, `xfer_go` pulses for one cycle afterwards and status bit 2 clears (unless `seq_err` sets it in the same cycle). The transfer count byte stores (value & 0x77).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| seq_pop | input | 1 | Sequencer takes the head byte |
| seq_push | input | 1 | Sequencer appends a received byte |
| seq_pdata | input | 8 | Received byte |
| seq_head | output | 8 | Head byte of the queue |
| buf_has | output | 1 | Queue holds at least one byte |
| buf_full | output | 1 | Queue holds four bytes |
| seq_irq | input | 1 | Transfer-complete event |
| seq_err | input | 1 | Transfer-abort event |
| bus_busy | input | 1 | Bus activity indication |
| ctrl_q | output | 8 | Stored control byte |
| mode_q | output | 8 | Stored mode byte |
| addr_lo | output | 8 | Low target address byte |
| addr_hi | output | 8 | High target address byte |
| xfer_go | output | 1 | One-cycle transfer start pulse |
| irq | output | 1 | Interrupt line |

## Verification
The queue is filled from one byte up to overflow and then drained past empty. This separates shifting errors from flag-timing errors and exposes any 0xFF mismatch. Writes and reads are interleaved with pushes and pops from the sequencer, including a pop and a push in the same cycle, which shows whether the stated priority holds. The interrupt path is tried with the enable on, then off, then on again, so that a status clear that drops the line unconditionally can be told apart from the correct gated one. A soft reset after every register has been loaded shows which registers it clears and that the address bytes survive.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int DW = 8;
    localparam int AW = 5;

    localparam logic [AW-1:0] OFS_DATA    = 5'd0;
    localparam logic [AW-1:0] OFS_ADDR_LO = 5'd4;
    localparam logic [AW-1:0] OFS_ADDR_HI = 5'd5;
    localparam logic [AW-1:0] OFS_CTRL    = 5'd6;
    localparam logic [AW-1:0] OFS_MODE    = 5'd7;
    localparam logic [AW-1:0] OFS_STAT    = 5'd8;
    localparam logic [AW-1:0] OFS_XSTAT   = 5'd9;
    localparam logic [AW-1:0] OFS_CLKDIV  = 5'd11;
    localparam logic [AW-1:0] OFS_IMASK   = 5'd12;
    localparam logic [AW-1:0] OFS_XCNT    = 5'd14;
    localparam logic [AW-1:0] OFS_XCTL    = 5'd15;
    localparam logic [AW-1:0] OFS_DIRECT  = 5'd16;

    localparam logic [DW-1:0] MODE_KEEP   = 8'h3D;
    localparam logic [DW-1:0] CTRL_KEEP   = 8'hFE;
    localparam logic [DW-1:0] XCNT_KEEP   = 8'h77;
    localparam logic [DW-1:0] XSTAT_W1C   = 8'h8F;
    localparam logic [DW-1:0] XSTAT_RST   = 8'h40;
    localparam logic [DW-1:0] EMPTY_READ  = 8'hFF;
    localparam logic [3:0]    DIRECT_RST  = 4'hF;

    localparam int MODE_FLUSH_BIT  = 6;
    localparam int MODE_IEN_BIT    = 2;
    localparam int STAT_IRQ_BIT    = 1;
    localparam int XSTAT_BUSY_BIT  = 4;
    localparam int CTRL_GO_BIT     = 0;
    localparam int SRST_BIT        = 0;

    typedef enum logic [1:0] {
        BUF_EMPTY   = 2'd0,
        BUF_PARTIAL = 2'd1,
        BUF_FULL    = 2'd2
    } buf_state_e;
endpackage

// File: rtl/i2cm_databuf.sv
module i2cm_databuf
    import i2cm_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] head,
    output logic             has_data,
    output logic             is_full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LAST_FREE = CW'(DEPTH - 1);
    localparam logic [CW-1:0] FILL_MAX  = CW'(DEPTH);

    buf_state_e       state_q, state_d;
    logic [CW-1:0]    fill_q, fill_d;
    logic [WIDTH-1:0] slot_q  [DEPTH];
    logic [WIDTH-1:0] slot_nx [DEPTH];
    logic             do_pop, do_push;

    // pop takes the cycle over push, flush overrides both
    always_comb begin
        do_pop  = pop && !flush && (state_q != BUF_EMPTY);
        do_push = push && !pop && !flush && (state_q != BUF_FULL);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: begin
                if (do_push) state_d = (DEPTH == 1) ? BUF_FULL : BUF_PARTIAL;
            end
            BUF_PARTIAL: begin
                if (do_push && fill_q == LAST_FREE) state_d = BUF_FULL;
                else if (do_pop && fill_q == CW'(1)) state_d = BUF_EMPTY;
            end
            BUF_FULL: begin
                if (do_pop) state_d = (DEPTH == 1) ? BUF_EMPTY : BUF_PARTIAL;
            end
            default: state_d = BUF_EMPTY;
        endcase
        if (flush) state_d = BUF_EMPTY;
    end

    always_comb begin
        if (flush)        fill_d = '0;
        else if (do_push) fill_d = fill_q + CW'(1);
        else if (do_pop)  fill_d = fill_q - CW'(1);
        else              fill_d = fill_q;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] above;
        if (i == DEPTH - 1) begin : g_top
            assign above = '0;
        end else begin : g_mid
            assign above = slot_q[i+1];
        end
        assign slot_nx[i] = flush                                 ? '0        :
                            do_pop                                ? above     :
                            (do_push && fill_q == CW'(i))         ? push_data :
                                                                    slot_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
            fill_q  <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_nx[i];
        end
    end

    always_comb begin
        head     = slot_q[0];
        has_data = (state_q != BUF_EMPTY);
        is_full  = (state_q == BUF_FULL);
    end

    assert_flags_track_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (has_data == (fill_q != '0)) && (is_full == (fill_q == FILL_MAX)));

    assert_full_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push && !pop && !flush) |=> (is_full && $stable(head)));

    assert_empty_pop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_data && pop && !flush) |=> !has_data);

    assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!has_data && head == '0));
endmodule

// File: rtl/i2cm_ctlregs.sv
module i2cm_ctlregs
    import i2cm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          seq_irq,
    input  logic          seq_err,
    output logic          soft_rst,
    output logic          xfer_go,
    output logic          irq,
    output logic          stat_err,
    output logic          stat_irq,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] mode,
    output logic [DW-1:0] addr_lo,
    output logic [DW-1:0] addr_hi,
    output logic [DW-1:0] clkdiv,
    output logic [DW-1:0] imask,
    output logic [DW-1:0] xcnt,
    output logic [DW-1:0] xstat,
    output logic [3:0]    direct
);
    logic go_req, stat_clr, irq_set, ien;

    always_comb begin
        soft_rst = wr && addr == OFS_XCTL && wdata[SRST_BIT];
        go_req   = wr && addr == OFS_CTRL && wdata[CTRL_GO_BIT];
        stat_clr = wr && addr == OFS_STAT && wdata[STAT_IRQ_BIT];
        ien      = mode[MODE_IEN_BIT];
        irq_set  = seq_irq && ien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo  <= '0;
            addr_hi  <= '0;
            ctrl     <= '0;
            mode     <= '0;
            clkdiv   <= '0;
            imask    <= '0;
            xcnt     <= '0;
            xstat    <= XSTAT_RST;
            direct   <= DIRECT_RST;
            stat_err <= 1'b0;
            stat_irq <= 1'b0;
            irq      <= 1'b0;
            xfer_go  <= 1'b0;
        end else if (soft_rst) begin
            ctrl     <= '0;
            mode     <= '0;
            clkdiv   <= '0;
            imask    <= '0;
            xcnt     <= '0;
            xstat    <= XSTAT_RST;
            direct   <= DIRECT_RST;
            stat_err <= 1'b0;
            stat_irq <= 1'b0;
            irq      <= 1'b0;
            xfer_go  <= 1'b0;
        end else begin
            xfer_go <= go_req;
            if (wr) begin
                unique case (addr)
                    OFS_ADDR_LO: addr_lo <= wdata;
                    OFS_ADDR_HI: addr_hi <= wdata;
                    OFS_CTRL:    ctrl    <= wdata & CTRL_KEEP;
                    OFS_MODE:    mode    <= wdata & MODE_KEEP;
                    OFS_CLKDIV:  clkdiv  <= wdata;
                    OFS_IMASK:   imask   <= wdata;
                    OFS_XCNT:    xcnt    <= wdata & XCNT_KEEP;
                    OFS_DIRECT:  direct  <= wdata[3:0];
                    default: ;
                endcase
            end
            if (seq_err)     stat_err <= 1'b1;
            else if (go_req) stat_err <= 1'b0;
            if (irq_set) begin
                stat_irq <= 1'b1;
                irq      <= 1'b1;
            end else if (stat_clr) begin
                stat_irq <= 1'b0;
                if (ien) irq <= 1'b0;
            end
            xstat <= ((wr && addr == OFS_XSTAT) ? (xstat & ~(wdata & XSTAT_W1C)) : xstat)
                     | DW'(seq_err);
        end
    end

    assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_irq && mode[MODE_IEN_BIT] && !soft_rst) |=> (irq && stat_irq));

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && mode[MODE_IEN_BIT] && !seq_irq) |=> !irq);

    assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (xstat == XSTAT_RST && mode == '0 && ctrl == '0 && direct == DIRECT_RST
                      && $stable(addr_lo) && $stable(addr_hi)));

    assert_abort_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !soft_rst) |=> (stat_err && xstat[0]));

    assert_go_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> $past(wr && addr == OFS_CTRL));
endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
    import i2cm_pkg::*;
#(
    parameter int BUF_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_rvalid,
    input  logic          seq_pop,
    input  logic          seq_push,
    input  logic [DW-1:0] seq_pdata,
    output logic [DW-1:0] seq_head,
    output logic          buf_has,
    output logic          buf_full,
    input  logic          seq_irq,
    input  logic          seq_err,
    input  logic          bus_busy,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] addr_lo,
    output logic [DW-1:0] addr_hi,
    output logic          xfer_go,
    output logic          irq
);
    logic          soft_rst, stat_err, stat_irq;
    logic          wr_data, rd_data, mode_flush;
    logic          q_flush, q_push, q_pop;
    logic [DW-1:0] q_pdata;
    logic [DW-1:0] clkdiv, imask, xcnt, xstat;
    logic [3:0]    direct;
    logic [DW-1:0] rd_mux;

    always_comb begin
        wr_data    = reg_wr && reg_addr == OFS_DATA;
        rd_data    = reg_rd && reg_addr == OFS_DATA;
        mode_flush = reg_wr && reg_addr == OFS_MODE && reg_wdata[MODE_FLUSH_BIT];
        q_flush    = soft_rst || mode_flush;
        q_pop      = rd_data || seq_pop;
        q_push     = wr_data || seq_push;
        q_pdata    = wr_data ? reg_wdata : seq_pdata;
    end

    i2cm_databuf #(.DEPTH(BUF_DEPTH), .WIDTH(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (q_flush),
        .push      (q_push),
        .pop       (q_pop),
        .push_data (q_pdata),
        .head      (seq_head),
        .has_data  (buf_has),
        .is_full   (buf_full)
    );

    i2cm_ctlregs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .seq_irq  (seq_irq),
        .seq_err  (seq_err),
        .soft_rst (soft_rst),
        .xfer_go  (xfer_go),
        .irq      (irq),
        .stat_err (stat_err),
        .stat_irq (stat_irq),
        .ctrl     (ctrl_q),
        .mode     (mode_q),
        .addr_lo  (addr_lo),
        .addr_hi  (addr_hi),
        .clkdiv   (clkdiv),
        .imask    (imask),
        .xcnt     (xcnt),
        .xstat    (xstat),
        .direct   (direct)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_DATA:    rd_mux = buf_has ? seq_head : EMPTY_READ;
            OFS_ADDR_LO: rd_mux = addr_lo;
            OFS_ADDR_HI: rd_mux = addr_hi;
            OFS_CTRL:    rd_mux = ctrl_q;
            OFS_MODE:    rd_mux = mode_q;
            OFS_STAT:    rd_mux = {2'b00, buf_has, buf_full, 1'b0, stat_err, stat_irq, 1'b0};
            OFS_XSTAT:   rd_mux = xstat | (DW'(bus_busy) << XSTAT_BUSY_BIT);
            OFS_CLKDIV:  rd_mux = clkdiv;
            OFS_IMASK:   rd_mux = imask;
            OFS_XCNT:    rd_mux = xcnt;
            OFS_DIRECT:  rd_mux = {4'b0000, direct};
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_empty_read_ff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !buf_has) |=> (reg_rdata == EMPTY_READ));

    assert_other_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != OFS_DATA && !reg_wr && !seq_pop && !seq_push) |=> $stable(seq_head));
endmodule

// File: tb/i2cm_regfile_test.sv
`timescale 1ns/1ps
module i2cm_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [4:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       reg_rvalid;
    logic       seq_pop = 0, seq_push = 0, seq_irq = 0, seq_err = 0, bus_busy = 0;
    logic [7:0] seq_pdata = 0;
    logic [7:0] seq_head, ctrl_q, mode_q, addr_lo, addr_hi;
    logic       buf_has, buf_full, xfer_go, irq;

    always #5 clk = ~clk;

    i2cm_regfile uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .seq_pop(seq_pop), .seq_push(seq_push), .seq_pdata(seq_pdata), .seq_head(seq_head),
        .buf_has(buf_has), .buf_full(buf_full), .seq_irq(seq_irq), .seq_err(seq_err),
        .bus_busy(bus_busy), .ctrl_q(ctrl_q), .mode_q(mode_q), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .xfer_go(xfer_go), .irq(irq)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R7";
    bit    cmp_en = 0;

    // behavioural reference model
    logic [7:0] q[$];
    logic [7:0] m_ctl = 0, m_mode = 0, m_alo = 0, m_ahi = 0, m_clk = 0, m_imask = 0, m_xcnt = 0;
    logic [7:0] m_ext = 8'h40;
    logic [3:0] m_dir = 4'hF;
    logic       m_err = 0, m_irqa = 0, m_irq = 0;
    logic       e_rv = 0, e_go = 0;
    logic [7:0] e_rd = 0, pd;
    logic       srst, fl, po, pu, ien;

    function automatic logic [7:0] mread(input logic [4:0] a);
        case (a)
            5'd0:  return (q.size() != 0) ? q[0] : 8'hFF;
            5'd4:  return m_alo;
            5'd5:  return m_ahi;
            5'd6:  return m_ctl;
            5'd7:  return m_mode;
            5'd8:  return {2'b00, q.size() != 0, q.size() == 4, 1'b0, m_err, m_irqa, 1'b0};
            5'd9:  return m_ext | {3'b000, bus_busy, 4'b0000};
            5'd11: return m_clk;
            5'd12: return m_imask;
            5'd14: return m_xcnt;
            5'd16: return {4'b0000, m_dir};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_ctl = 0; m_mode = 0; m_alo = 0; m_ahi = 0; m_clk = 0; m_imask = 0; m_xcnt = 0;
            m_ext = 8'h40; m_dir = 4'hF; m_err = 0; m_irqa = 0; m_irq = 0;
            e_rv = 0; e_go = 0; e_rd = 0;
        end else begin
            srst = reg_wr && reg_addr == 5'd15 && reg_wdata[0];
            e_rv = reg_rd;
            if (reg_rd) e_rd = mread(reg_addr);
            e_go = reg_wr && reg_addr == 5'd6 && reg_wdata[0];
            fl = srst || (reg_wr && reg_addr == 5'd7 && reg_wdata[6]);
            po = (reg_rd && reg_addr == 5'd0) || seq_pop;
            pu = (reg_wr && reg_addr == 5'd0) || seq_push;
            pd = (reg_wr && reg_addr == 5'd0) ? reg_wdata : seq_pdata;
            if (fl) q.delete();
            else if (po) begin
                if (q.size() != 0) q.delete(0);
            end else if (pu && q.size() < 4) q.push_back(pd);
            if (srst) begin
                m_ctl = 0; m_mode = 0; m_clk = 0; m_imask = 0; m_xcnt = 0;
                m_ext = 8'h40; m_dir = 4'hF; m_err = 0; m_irqa = 0; m_irq = 0; e_go = 0;
            end else begin
                ien = m_mode[2];
                if (seq_err) m_err = 1; else if (e_go) m_err = 0;
                if (seq_irq && ien) begin m_irqa = 1; m_irq = 1; end
                else if (reg_wr && reg_addr == 5'd8 && reg_wdata[1]) begin
                    m_irqa = 0;
                    if (ien) m_irq = 0;
                end
                if (reg_wr && reg_addr == 5'd9) m_ext = m_ext & ~(reg_wdata & 8'h8F);
                if (seq_err) m_ext[0] = 1'b1;
                if (reg_wr) begin
                    case (reg_addr)
                        5'd4:  m_alo = reg_wdata;
                        5'd5:  m_ahi = reg_wdata;
                        5'd6:  m_ctl = reg_wdata & 8'hFE;
                        5'd7:  m_mode = reg_wdata & 8'h3D;
                        5'd11: m_clk = reg_wdata;
                        5'd12: m_imask = reg_wdata;
                        5'd14: m_xcnt = reg_wdata & 8'h77;
                        5'd16: m_dir = reg_wdata[3:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input logic ok, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compared on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(reg_rvalid === e_rv, "rvalid", {7'b0, reg_rvalid}, {7'b0, e_rv});
            if (e_rv) chk(reg_rdata === e_rd, "rdata", reg_rdata, e_rd);
            chk(buf_has === (q.size() != 0), "has", {7'b0, buf_has}, {7'b0, q.size() != 0});
            chk(buf_full === (q.size() == 4), "full", {7'b0, buf_full}, {7'b0, q.size() == 4});
            if (q.size() != 0) chk(seq_head === q[0], "head", seq_head, q[0]);
            chk(irq === m_irq, "irq", {7'b0, irq}, {7'b0, m_irq});
            chk(xfer_go === e_go, "go", {7'b0, xfer_go}, {7'b0, e_go});
            chk(ctrl_q === m_ctl, "ctrl", ctrl_q, m_ctl);
            chk(mode_q === m_mode, "mode", mode_q, m_mode);
            chk(addr_lo === m_alo, "addr_lo", addr_lo, m_alo);
            chk(addr_hi === m_ahi, "addr_hi", addr_hi, m_ahi);
        end
    end

    task automatic step();
        @(negedge clk); #1;
        reg_wr = 0; reg_rd = 0; seq_pop = 0; seq_push = 0; seq_irq = 0; seq_err = 0;
    endtask
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; step();
    endtask
    task automatic rd(input logic [4:0] a);
        reg_rd = 1; reg_addr = a; step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1; cmp_en = 1;
        cur_req = "R7 reset";
        rd(5'd8); rd(5'd9); rd(5'd16); rd(5'd6); rd(5'd7);
        cur_req = "R3 empty";
        rd(5'd0); rd(5'd8);
        cur_req = "R7 addr";
        wr(5'd4, 8'hA6); wr(5'd5, 8'h3C); rd(5'd4); rd(5'd5);
        cur_req = "R1 fill";
        wr(5'd0, 8'h11); rd(5'd8); wr(5'd0, 8'h22); wr(5'd0, 8'h33); wr(5'd0, 8'h44); rd(5'd8);
        cur_req = "R2 overflow";
        wr(5'd0, 8'h55); rd(5'd8);
        cur_req = "R4 drain";
        for (int i = 0; i < 5; i++) begin rd(5'd0); rd(5'd8); end
        cur_req = "R5 mode";
        wr(5'd7, 8'hFF); rd(5'd7); wr(5'd0, 8'h01); wr(5'd0, 8'h02);
        wr(5'd7, 8'h44); rd(5'd8); rd(5'd0); wr(5'd0, 8'h9C); rd(5'd0);
        cur_req = "R6 irq";
        seq_irq = 1; step(); rd(5'd8);
        wr(5'd8, 8'h04); rd(5'd8); wr(5'd8, 8'h02); rd(5'd8);
        wr(5'd7, 8'h00); seq_irq = 1; step(); rd(5'd8);
        wr(5'd7, 8'h04); seq_irq = 1; step(); wr(5'd7, 8'h00); wr(5'd8, 8'h02); rd(5'd8);
        wr(5'd7, 8'h04); wr(5'd8, 8'h02); step();
        cur_req = "R8 xstat";
        bus_busy = 1; rd(5'd9); seq_err = 1; step(); rd(5'd9); rd(5'd8);
        wr(5'd9, 8'hFF); rd(5'd9); bus_busy = 0; rd(5'd9);
        cur_req = "R11 ctrl";
        seq_err = 1; step(); wr(5'd6, 8'h37); step(); rd(5'd6); rd(5'd8);
        wr(5'd14, 8'hFF); rd(5'd14);
        cur_req = "R10 seq";
        seq_push = 1; seq_pdata = 8'hC1; step();
        seq_push = 1; seq_pdata = 8'hC2; step();
        seq_push = 1; seq_pdata = 8'hC3; step();
        seq_pop = 1; step();
        seq_pop = 1; seq_push = 1; seq_pdata = 8'hEE; step();
        rd(5'd8); wr(5'd0, 8'h77); seq_push = 1; seq_pdata = 8'h78; step(); rd(5'd0);
        cur_req = "R9 side";
        rd(5'd4); rd(5'd9); rd(5'd3); wr(5'd5, 8'h5A); rd(5'd0);
        cur_req = "R7 soft";
        wr(5'd11, 8'h5A); wr(5'd12, 8'h0F); wr(5'd16, 8'hA5); wr(5'd6, 8'hF0);
        wr(5'd7, 8'h04); seq_irq = 1; step(); wr(5'd0, 8'h42);
        rd(5'd11); rd(5'd12); rd(5'd16);
        wr(5'd15, 8'h01);
        rd(5'd4); rd(5'd5); rd(5'd9); rd(5'd16); rd(5'd11); rd(5'd12); rd(5'd14); rd(5'd8); rd(5'd0);
        step(); step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL %s watchdog: got running expected finished", cur_req);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule